// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the fetch stage of an in-order processor with fetch, decode, read and execute stages. It lets a repeat command run either one instruction or a block of instructions several times without a taken branch on each pass. When the command executes, it arms a dedicated down-counter and latches the first and last addresses of the loop body. From then on, each time fetch presents the last address while the counter is nonzero, the controller returns the loop-start address on the redirect output in the same cycle and decrements the counter. The pipeline therefore stays full of loop instructions. When the counter reaches zero, fetch falls through to the code after the loop.

Arming a loop costs a single pipeline flush, which appears as a one-cycle flush pulse. Later passes add no cycles. The counter operand holds the number of extra passes, which is the total count minus one. The body therefore runs `count + 1` times, and a count of zero runs it once and arms nothing. In single-instruction mode the body is the one instruction at the start address. While such a loop runs, interrupts are held off. A second repeat command issued while a loop is armed is rejected and flagged.

Top module: `hwl_ctrl`

## Requirements
- R1: After reset `loop_active`, `redirect_valid`, `flush_pulse`, `setup_err` and `irq_hold` are all 0.
- R2: With `setup_single`=0, an accepted setup latches `setup_start` and `setup_end`. While a loop is armed, a cycle with `fetch_valid`=1 and `fetch_pc` equal to the latched end gives `redirect_valid`=1 with `redirect_pc` equal to the latched start in that same cycle.
- R3: A setup with count C > 0 produces exactly C redirects. After them, `fetch_pc` at the loop end gives no redirect.
- R4: With `setup_single`=1, both the loop start and the loop end are `setup_start`, and `setup_end` has no effect.
- R5: A setup with count 0 leaves `loop_active` at 0 and produces no redirect.
- R6: `flush_pulse` is 1 for exactly the one cycle after an accepted setup. It is 0 during the iterations.
- R7: `setup_valid`=1 while `loop_active`=1 makes `setup_err` 1 in the next cycle with no flush. The latched addresses and the remaining count are unchanged.
- R8: `irq_hold` is 1 exactly while a single-instruction loop is armed. It is 0 for block loops.
- R9: With `fetch_valid`=0, the end address gives no redirect and does not use up an iteration.
- R10: `loop_active` rises only on the cycle after an accepted setup. It falls only on the cycle after the final redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch is issuing `fetch_pc` this cycle |
| fetch_pc | input | AW | Current fetch address |
| setup_valid | input | 1 | Repeat command executes this cycle |
| setup_single | input | 1 | 1 = single-instruction repeat, 0 = block repeat |
| setup_count | input | CW | Number of extra passes (total minus one) |
| setup_start | input | AW | First address of the loop body |
| setup_end | input | AW | Last address of the body (block mode only) |
| redirect_valid | output | 1 | Replace the next fetch address with `redirect_pc` |
| redirect_pc | output | AW | Loop start address |
| flush_pulse | output | 1 | One-cycle flush request after loop setup |
| loop_active | output | 1 | Loop counter is nonzero |
| setup_err | output | 1 | One-cycle flag: setup issued while a loop was armed |
| irq_hold | output | 1 | Interrupts must be held off |

## Verification
The embedded assertions check on every cycle that:
- the counter drops by exactly one per redirect and holds otherwise;
- the latched addresses move only on an accepted setup;
- `loop_active` changes only after an accepted setup or a final redirect;
- `irq_hold` never appears without an armed loop.

Only the bench's scenarios can show that the number of passes equals the programmed count in both modes and for a zero count. The same holds for the rule that a rejected setup leaves the running loop's addresses and remaining passes intact, and for the rule that a stalled fetch at the loop end consumes nothing.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef enum logic {
    HWL_BLOCK  = 1'b0,
    HWL_SINGLE = 1'b1
  } hwl_mode_e;
endpackage

// File: rtl/hwl_count.sv
module hwl_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] cnt_q,
  output logic          nonzero
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_q - 1'b1;
  end

  assign nonzero = (cnt_q != '0);

  // R3: each redirect uses up exactly one pass
  p_step_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R9: no step and no load leaves the count alone
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/hwl_addr.sv
module hwl_addr
  import hwl_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  hwl_mode_e     mode,
  input  logic [AW-1:0] start_in,
  input  logic [AW-1:0] end_in,
  input  logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] last_q,
  output logic          at_end
);
  logic [AW-1:0] last_sel;
  assign last_sel = (mode == HWL_SINGLE) ? start_in : end_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      last_q  <= '0;
    end else if (load) begin
      start_q <= start_in;
      last_q  <= last_sel;
    end
  end

  assign at_end = (fetch_pc == last_q);

  // R7: the loop bounds move only on an accepted setup
  p_bounds_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(start_q) && $stable(last_q)));
endmodule

// File: rtl/hwl_ctrl.sv
module hwl_ctrl
  import hwl_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          setup_valid,
  input  logic          setup_single,
  input  logic [CW-1:0] setup_count,
  input  logic [AW-1:0] setup_start,
  input  logic [AW-1:0] setup_end,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          flush_pulse,
  output logic          loop_active,
  output logic          setup_err,
  output logic          irq_hold
);
  logic          accept;
  logic          hit;
  logic          at_end;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] start_q;
  logic [AW-1:0] last_q;
  hwl_mode_e     mode_in;
  hwl_mode_e     mode_q;
  logic          flush_q;
  logic          err_q;

  assign mode_in = setup_single ? HWL_SINGLE : HWL_BLOCK;
  assign accept  = setup_valid && !loop_active;
  assign hit     = loop_active && fetch_valid && at_end;

  hwl_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (setup_count),
    .step     (hit),
    .cnt_q    (cnt_q),
    .nonzero  (loop_active)
  );

  hwl_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .mode     (mode_in),
    .start_in (setup_start),
    .end_in   (setup_end),
    .fetch_pc (fetch_pc),
    .start_q  (start_q),
    .last_q   (last_q),
    .at_end   (at_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= HWL_BLOCK;
      flush_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (accept) mode_q <= mode_in;
      flush_q <= accept;
      err_q   <= setup_valid && loop_active;
    end
  end

  assign redirect_valid = hit;
  assign redirect_pc    = start_q;
  assign flush_pulse    = flush_q;
  assign setup_err      = err_q;
  assign irq_hold       = loop_active && (mode_q == HWL_SINGLE);

  // R10: arming happens only through a setup
  p_rise_after_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_active) |-> $past(setup_valid));
  // R10: disarming happens only after the final redirect
  p_fall_after_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loop_active) |-> $past(redirect_valid));
  // R8: interrupt hold requires an armed loop
  p_irq_hold_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hold |-> loop_active);
  // R7: a rejected setup is flagged and takes no flush
  p_err_no_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && loop_active) |=> (setup_err && !flush_pulse));
  // R6: flush and error never coincide
  p_flush_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_pulse && setup_err));
endmodule

// File: tb/hwl_ctrl_tb_top.sv
`timescale 1ns/100ps
module hwl_ctrl_tb_top;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          setup_valid = 1'b0;
  logic          setup_single = 1'b0;
  logic [CW-1:0] setup_count = '0;
  logic [AW-1:0] setup_start = '0;
  logic [AW-1:0] setup_end = '0;
  logic          redirect_valid;
  logic [AW-1:0] redirect_pc;
  logic          flush_pulse;
  logic          loop_active;
  logic          setup_err;
  logic          irq_hold;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  hwl_ctrl #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .setup_valid(setup_valid), .setup_single(setup_single),
    .setup_count(setup_count), .setup_start(setup_start), .setup_end(setup_end),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .flush_pulse(flush_pulse), .loop_active(loop_active),
    .setup_err(setup_err), .irq_hold(irq_hold)
  );

  task automatic chk(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue_setup(bit single, int cnt, int s, int e);
    @(negedge clk);
    fetch_valid  = 1'b0;
    setup_valid  = 1'b1;
    setup_single = single;
    setup_count  = CW'(cnt);
    setup_start  = AW'(s);
    setup_end    = AW'(e);
    @(negedge clk);
    setup_valid = 1'b0;
    #1;
  endtask

  // Walk fetch through the loop body until it falls out; returns redirect count.
  task automatic run_body(int s, int e, bit single, int max_red, output int reds);
    int pc;
    reds = 0;
    pc = s;
    for (int guard = 0; guard < 4000; guard++) begin
      @(negedge clk);
      fetch_valid = 1'b1;
      fetch_pc    = AW'(pc);
      #1;
      chk("R6 no flush during loop", flush_pulse, 0);
      chk("R8 irq_hold", irq_hold, single && loop_active);
      if (redirect_valid) begin
        chk("R2 redirect target", redirect_pc, s);
        chk("R2 redirect at end", pc, e);
        reds++;
        pc = s;
      end else if (pc == e) begin
        break;
      end else begin
        pc++;
      end
      if (reds > max_red) break;
    end
    @(negedge clk);
    fetch_valid = 1'b0;
    #1;
  endtask

  task automatic one_loop(bit single, int cnt, int s, int e);
    int reds;
    int le;
    le = single ? s : e;
    issue_setup(single, cnt, s, e);
    chk("R6 flush after setup", flush_pulse, 1);
    chk("R5/R10 active after setup", loop_active, cnt != 0);
    chk("R8 irq_hold after setup", irq_hold, single && (cnt != 0));
    run_body(s, le, single, cnt, reds);
    chk(single ? "R4 single pass count" : "R3 block pass count", reds, cnt);
    chk("R10 inactive after loop", loop_active, 0);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_pc    = AW'(le);
    #1;
    chk("R3 fall through at end", redirect_valid, 0);
    @(negedge clk);
    fetch_valid = 1'b0;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int reds;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 loop_active", loop_active, 0);
    chk("R1 redirect_valid", redirect_valid, 0);
    chk("R1 flush_pulse", flush_pulse, 0);
    chk("R1 setup_err", setup_err, 0);
    chk("R1 irq_hold", irq_hold, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R5: block sweep over counts and body lengths
    for (int c = 0; c <= 6; c++)
      for (int len = 1; len <= 4; len++)
        one_loop(1'b0, c, 16'h0100 + 8 * len, 16'h0100 + 8 * len + len - 1);

    // R4 R8: single-instruction sweep, setup_end set to an unrelated value
    for (int c = 0; c <= 9; c++)
      one_loop(1'b1, c, 16'h0200 + c, 16'h0F00);

    // R7 R9: rejected setup and stalled fetch during a block loop of 3 passes
    issue_setup(1'b0, 3, 16'h0300, 16'h0302);
    chk("R6 flush", flush_pulse, 1);
    @(negedge clk);
    fetch_valid = 1'b0;
    fetch_pc    = 16'h0302;
    #1;
    chk("R9 no redirect when stalled", redirect_valid, 0);
    @(negedge clk);
    setup_valid  = 1'b1;
    setup_single = 1'b1;
    setup_count  = 8'd9;
    setup_start  = 16'h0700;
    setup_end    = 16'h0777;
    @(negedge clk);
    setup_valid = 1'b0;
    #1;
    chk("R7 setup_err", setup_err, 1);
    chk("R7 no flush", flush_pulse, 0);
    chk("R7 irq_hold unchanged", irq_hold, 0);
    @(negedge clk);
    #1;
    chk("R7 err is one pulse", setup_err, 0);
    run_body(16'h0300, 16'h0302, 1'b0, 3, reds);
    chk("R7/R9 remaining passes", reds, 3);
    chk("R10 inactive", loop_active, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule